// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter inside a small microcontroller. Software talks to it through four 8-bit registers on a simple write strobe / combinational read bus. One register picks the conversion clock as a division of the system clock. A second register carries the start bit, the end-of-conversion flag and the input channel number. A third returns the last result, and a fourth holds the interrupt request flag and its two enables.

A conversion is requested by toggling the start bit up and then down. The upward write puts the converter back into its reset condition and cancels any conversion under way. The downward write launches a new one. The sequencer spends one conversion-clock period sampling. It then resolves one result bit per period, most significant bit first, by presenting a trial code to an external DAC/comparator pair and reading back a single compare bit. When the last bit is decided, the result is latched, the end-of-conversion flag drops and the interrupt request flag is raised.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion-clock select field is bits [1:0] of the clock register at address 0. Code 0 divides the system clock by 2, code 1 by 8 and code 2 by 32. A conversion lasts 9 conversion-clock periods. Counted from the clock edge that accepts the start-low write to the edge that clears end-of-conversion, that is 18, 72 or 288 system cycles.
- R2: Select code 3 behaves exactly like code 2 (divide by 32), and changing the select value never stalls the divider.
- R3: In the clock register, bits 6..2 always read 0, while bit 7 and bits [1:0] read back as written. Bit 7 has no effect on conversion timing or results.
- R4: Writing the start bit (bit 7 of the control register, address 1) from 0 to 1 aborts a running conversion. No result is latched, the result register keeps its old value, the request flag is not set, and end-of-conversion stays 1.
- R5: Writing the start bit from 1 to 0 launches a conversion. Writing the same value the bit already holds launches nothing.
- R6: End-of-conversion (bit 6 of the control register, read-only, 0 after reset) becomes 1 on either start-bit edge and stays 1 until a conversion finishes, when it becomes 0.
- R7: The trial code is 0 during the sample period and 0x80 during the first bit period. Each bit is kept when the compare input is 1. With a comparator that reports input >= trial, the result at address 2 equals the input value.
- R8: On completion, the request flag (bit 0 of address 3) is set. It stays set until software writes 0 to it.
- R9: The interrupt output is 1 only when the request flag, the A/D enable (bit 1 of address 3) and the global enable (bit 2 of address 3) are all 1.
- R10: The channel field (bits [2:0] of the control register) drives the channel output directly while idle. A channel write during a conversion leaves the output unchanged until the converter is idle.
- R11: The result register changes only at conversion completion. Reading any register has no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| cmp_hi | input | 1 | Comparator result: analog input at or above trial code |
| dac_code | output | 8 | Trial code driven to the DAC |
| ch_sel | output | 3 | Channel driven to the analog multiplexer |
| irq | output | 1 | A/D interrupt request |

## Verification
The assertions assume that the compare input is settled and valid in every cycle. They also assume that the select field never holds a divisor below 2, which the parameter checks guarantee. The bench models the comparator as a combinational compare of a held analog value against the trial code, so the compare input is always defined. The analog value changes only while the converter is idle. Register writes are driven away from the clock edge, one cycle at a time, so each start-bit edge is a single clean write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SAR_IDLE    = 2'd0,
      SAR_SAMPLE  = 2'd1,
      SAR_RESOLVE = 2'd2
   } sar_state_e;

   localparam logic [1:0] REG_CLKSEL = 2'd0;
   localparam logic [1:0] REG_CTRL   = 2'd1;
   localparam logic [1:0] REG_RESULT = 2'd2;
   localparam logic [1:0] REG_IRQ    = 2'd3;

endpackage

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
   parameter int DIV_A = 2,
   parameter int DIV_B = 8,
   parameter int DIV_C = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       clear,
   input  logic       run,
   output logic       tick
);
   localparam int DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int DIV_MAX = (DIV_C > DIV_AB) ? DIV_C : DIV_AB;
   localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

   if (DIV_A < 2 || DIV_B < 2 || DIV_C < 2) begin : g_bad_div
      $error("adc_clk_prescaler: every divisor must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit_m1;

   // code 3 shares the slowest divisor (R2)
   always_comb begin
      case (sel)
         2'd0:    limit_m1 = CNT_W'(DIV_A - 1);
         2'd1:    limit_m1 = CNT_W'(DIV_B - 1);
         default: limit_m1 = CNT_W'(DIV_C - 1);
      endcase
   end

   // ">=" keeps the divider alive when sel shrinks mid-count (R2)
   assign tick = run && (cnt >= limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clear || !run) cnt <= '0;
      else if (tick)          cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   // every divisor is at least 2, so ticks never come back to back
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clear) |=> !tick);

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             abort,
   input  logic             tick,
   input  logic             cmp_hi,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] final_code
);
   localparam int IDX_W = (RES_W > 2) ? $clog2(RES_W) : 1;
   localparam logic [RES_W-1:0] MSB_CODE = {1'b1, {(RES_W-1){1'b0}}};

   if (RES_W < 2) begin : g_bad_res
      $error("adc_sar_engine: RES_W must be at least 2");
   end

   sar_state_e       st;
   logic [RES_W-1:0] acc;
   logic [IDX_W-1:0] idx;
   logic [RES_W-1:0] resolved;

   // per-bit trial and decision logic
   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      logic on_bit;
      assign on_bit      = (st == SAR_RESOLVE) && (idx == IDX_W'(i));
      assign trial[i]    = acc[i] | on_bit;
      assign resolved[i] = on_bit ? cmp_hi : acc[i];
   end

   assign busy       = (st != SAR_IDLE);
   assign final_code = resolved;
   assign done       = (st == SAR_RESOLVE) && tick && (idx == '0) && !abort && !launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SAR_IDLE;
         acc <= '0;
         idx <= '0;
      end else if (abort) begin
         st  <= SAR_IDLE;
         acc <= '0;
         idx <= '0;
      end else if (launch) begin
         st  <= SAR_SAMPLE;
         acc <= '0;
         idx <= '0;
      end else if (tick) begin
         case (st)
            SAR_SAMPLE: begin
               st  <= SAR_RESOLVE;
               idx <= IDX_W'(RES_W - 1);
            end
            SAR_RESOLVE: begin
               acc <= resolved;
               if (idx == '0) st  <= SAR_IDLE;
               else           idx <= idx - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assert_launch_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !abort) |=> busy);

   assert_abort_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);

   assert_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SAR_SAMPLE && tick && !abort && !launch) |=> (trial == MSB_CODE));

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
   import adc_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RES_W  = 8,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [RES_W-1:0]  final_code,
   output logic [1:0]        clk_sel,
   output logic              launch,
   output logic              abort,
   output logic [CH_W-1:0]   ch_sel,
   output logic              irq
);
   localparam int START_BIT = DATA_W - 1;
   localparam int EOC_BIT   = DATA_W - 2;
   localparam int TEST_BIT  = DATA_W - 1;

   logic              test_q;
   logic [1:0]        sel_q;
   logic              start_q;
   logic              eoc_q;
   logic [CH_W-1:0]   ch_pend;
   logic [CH_W-1:0]   ch_lat;
   logic [RES_W-1:0]  result_q;
   logic              flag_q;
   logic              ade_q;
   logic              gie_q;
   logic              wr_clk;
   logic              wr_ctrl;
   logic              wr_irq;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   assign wr_clk  = wr_en && (addr == REG_CLKSEL);
   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign wr_irq  = wr_en && (addr == REG_IRQ);

   // start-bit edge decode: up aborts, down launches
   assign abort  = wr_ctrl && !start_q &&  wdata[START_BIT];
   assign launch = wr_ctrl &&  start_q && !wdata[START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_q <= 1'b0;
         sel_q  <= 2'd0;
      end else if (wr_clk) begin
         test_q <= wdata[TEST_BIT];
         sel_q  <= wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         ch_pend <= '0;
      end else if (wr_ctrl) begin
         start_q <= wdata[START_BIT];
         ch_pend <= wdata[CH_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ch_lat <= '0;
      else if (launch) ch_lat <= wdata[CH_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                eoc_q <= 1'b0;
      else if (abort || launch)  eoc_q <= 1'b1;
      else if (done)             eoc_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    result_q <= '0;
      else if (done) result_q <= final_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ade_q  <= 1'b0;
         gie_q  <= 1'b0;
      end else begin
         if (done)        flag_q <= 1'b1;
         else if (wr_irq) flag_q <= wdata[0];
         if (wr_irq) begin
            ade_q <= wdata[1];
            gie_q <= wdata[2];
         end
      end
   end

   assign clk_sel = sel_q;
   assign ch_sel  = busy ? ch_lat : ch_pend;
   assign irq     = flag_q && ade_q && gie_q;

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CLKSEL: begin
            rdata[1:0]      = sel_q;
            rdata[TEST_BIT] = test_q;
         end
         REG_CTRL: begin
            rdata            = DATA_W'(ch_pend);
            rdata[START_BIT] = start_q;
            rdata[EOC_BIT]   = eoc_q;
         end
         REG_RESULT: rdata = DATA_W'(result_q);
         default: begin
            rdata[0] = flag_q;
            rdata[1] = ade_q;
            rdata[2] = gie_q;
         end
      endcase
   end

   assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (flag_q && !eoc_q));

   assert_busy_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> eoc_q);

   assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag_q);

   assert_ch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ch_sel));

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done) |-> $stable(result_q));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int DATA_W = 8,
   parameter int RES_W  = 8,
   parameter int CH_W   = 3,
   parameter int DIV_A  = 2,
   parameter int DIV_B  = 8,
   parameter int DIV_C  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              cmp_hi,
   output logic [RES_W-1:0]  dac_code,
   output logic [CH_W-1:0]   ch_sel,
   output logic              irq
);
   if (RES_W > DATA_W) begin : g_bad_res
      $error("adc_seq_ctrl: result wider than the register bus");
   end
   if (CH_W > DATA_W - 2) begin : g_bad_ch
      $error("adc_seq_ctrl: channel field overlaps start/eoc bits");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("adc_seq_ctrl: register bus too narrow");
   end

   logic [1:0]       clk_sel;
   logic             launch;
   logic             abort;
   logic             tick;
   logic             busy;
   logic             done;
   logic [RES_W-1:0] final_code;

   adc_ctrl_regs #(
      .DATA_W (DATA_W),
      .RES_W  (RES_W),
      .CH_W   (CH_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .rdata      (rdata),
      .busy       (busy),
      .done       (done),
      .final_code (final_code),
      .clk_sel    (clk_sel),
      .launch     (launch),
      .abort      (abort),
      .ch_sel     (ch_sel),
      .irq        (irq)
   );

   adc_clk_prescaler #(
      .DIV_A (DIV_A),
      .DIV_B (DIV_B),
      .DIV_C (DIV_C)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (clk_sel),
      .clear (launch || abort),
      .run   (busy),
      .tick  (tick)
   );

   adc_sar_engine #(
      .RES_W (RES_W)
   ) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .abort      (abort),
      .tick       (tick),
      .cmp_hi     (cmp_hi),
      .busy       (busy),
      .done       (done),
      .trial      (dac_code),
      .final_code (final_code)
   );

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       cmp_hi;
   logic [7:0] dac_code;
   logic [2:0] ch_sel;
   logic       irq;
   logic [7:0] ana = 8'd0;

   int n_chk = 0;
   int n_bad = 0;
   logic ade_m = 1'b0;
   logic gie_m = 1'b0;
   logic [2:0] ch_m = 3'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign cmp_hi = (ana >= dac_code);

   adc_seq_ctrl u_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cmp_hi(cmp_hi), .dac_code(dac_code), .ch_sel(ch_sel), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic int div_of(input int s);
      return (s == 0) ? 2 : (s == 1) ? 8 : 32;
   endfunction

   // one full conversion, with optional trial-order checks
   task automatic conv(input int s, input logic [7:0] v, input bit chk_trial);
      logic [7:0] r;
      int n;
      int d;
      d = div_of(s);
      ana = v;
      wr(2'd1, {1'b1, 4'b0, ch_m});
      rd(2'd1, r);
      chk("R6 eoc after start-high", r[6], 1);
      wr(2'd1, {1'b0, 4'b0, ch_m});
      n = 0;
      if (chk_trial) begin
         chk("R7 sample trial", dac_code, 0);
         repeat (d) begin @(negedge clk); n++; end
         chk("R7 first trial", dac_code, 8'h80);
         repeat (d) begin @(negedge clk); n++; end
         chk("R7 second trial", dac_code, {v[7], 1'b1, 6'b0});
      end
      rd(2'd1, r);
      while (r[6] && n < 2000) begin
         @(negedge clk); n++;
         rd(2'd1, r);
      end
      chk((s == 3) ? "R2 duration code3" : "R1 duration", n, 9 * d);
      rd(2'd2, r);
      chk("R7 result", r, v);
      rd(2'd3, r);
      chk("R8 flag set", r[0], 1);
      chk("R9 irq gating", irq, ade_m & gie_m);
      wr(2'd3, {5'b0, gie_m, ade_m, 1'b0});
      rd(2'd3, r);
      chk("R8 flag cleared", r[0], 0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], r);
         chk("R6 reset regs", r, 0);
      end
      chk("R9 reset irq", irq, 0);
      chk("R10 reset ch", ch_sel, 0);

      // clock register readback
      wr(2'd0, 8'hFF);
      rd(2'd0, r);
      chk("R3 clk reg readback", r, 8'h83);
      wr(2'd0, 8'h7C);
      rd(2'd0, r);
      chk("R3 unused bits", r, 8'h00);

      // channel while idle
      ch_m = 3'd5;
      wr(2'd1, 8'h05);
      chk("R10 idle channel", ch_sel, 5);
      rd(2'd1, r);
      chk("R5 same-value write no launch", r[6], 0);

      // irq fully enabled
      ade_m = 1'b1; gie_m = 1'b1;
      wr(2'd3, 8'h06);

      // exhaustive sweep at divide-by-2
      wr(2'd0, 8'h00);
      for (int v = 0; v < 256; v++) conv(0, v[7:0], (v % 37) == 0);

      // other divisors, test bit set on code 1
      wr(2'd0, 8'h81);
      conv(1, 8'h00, 1'b1);
      conv(1, 8'hFF, 1'b0);
      conv(1, 8'h5A, 1'b0);
      wr(2'd0, 8'h02);
      conv(2, 8'hA5, 1'b1);
      conv(2, 8'h01, 1'b0);
      wr(2'd0, 8'h03);
      conv(3, 8'h3C, 1'b0);
      conv(3, 8'hC3, 1'b0);

      // select change mid-conversion must not stall (R2)
      wr(2'd0, 8'h02);
      ana = 8'h44;
      wr(2'd1, {5'b10000, ch_m});
      wr(2'd1, {5'b00000, ch_m});
      repeat (20) @(negedge clk);
      wr(2'd0, 8'h00);
      repeat (400) @(negedge clk);
      rd(2'd1, r);
      chk("R2 no lockup", r[6], 0);
      rd(2'd2, r);
      chk("R2 no lockup result", r, 8'h44);
      wr(2'd3, 8'h06);

      // abort mid-conversion
      wr(2'd0, 8'h01);
      conv(1, 8'h11, 1'b0);
      ana = 8'h77;
      wr(2'd1, {5'b10000, ch_m});
      wr(2'd1, {5'b00000, ch_m});
      repeat (20) @(negedge clk);
      wr(2'd1, {5'b10000, ch_m});
      repeat (120) @(negedge clk);
      rd(2'd1, r);
      chk("R4 eoc held after abort", r[6], 1);
      rd(2'd2, r);
      chk("R4 result kept", r, 8'h11);
      rd(2'd3, r);
      chk("R4 no flag", r[0], 0);
      wr(2'd1, {5'b00000, ch_m});
      repeat (80) @(negedge clk);
      rd(2'd2, r);
      chk("R5 relaunch result", r, 8'h77);
      wr(2'd3, 8'h06);

      // channel deferred during conversion
      ana = 8'h20;
      wr(2'd1, {5'b10000, ch_m});
      wr(2'd1, {5'b00000, ch_m});
      wr(2'd1, 8'h02);
      chk("R10 ch held while busy", ch_sel, 5);
      repeat (80) @(negedge clk);
      chk("R10 ch applied when idle", ch_sel, 2);
      ch_m = 3'd2;
      wr(2'd3, 8'h06);

      // reads have no side effects
      rd(2'd2, r);
      chk("R11 result after reads", r, 8'h20);
      for (int a = 0; a < 4; a++) rd(a[1:0], r);
      rd(2'd2, r);
      chk("R11 result stable", r, 8'h20);

      // irq gating: global off, then enable only
      gie_m = 1'b0;
      wr(2'd3, 8'h02);
      conv(1, 8'h9E, 1'b0);
      ade_m = 1'b0; gie_m = 1'b1;
      wr(2'd3, 8'h04);
      conv(1, 8'h61, 1'b0);
      ade_m = 1'b1;
      wr(2'd3, 8'h07);
      @(negedge clk);
      chk("R9 irq all set", irq, 1);
      rd(2'd3, r);
      chk("R8 flag written", r[0], 1);
      wr(2'd3, 8'h06);
      chk("R8 flag cleared irq", irq, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule